// File: doc/BRIEF.md
# Peripheral Register Page Slave

This block is a peripheral slave on a simple two-phase register bus. It owns a fixed page of byte addresses, 1 KiB by default, and holds only a small bank of word registers at the bottom of that page. A master drives select, write, address and write data in a setup cycle. In the following cycle it raises enable, which starts the access phase. The slave holds ready low for a fixed number of wait cycles and then completes the transfer. On that completion cycle it returns read data and an error flag.

An access is aborted with the error flag in two cases: it lands inside the page but above the register bank, or it writes a register marked read-only. An aborted write changes no register. Read-only registers return a fixed identification constant. Writable registers come out of reset holding zero. The address decoder that raises select for this page sits outside the block. The bits of the address port that index into the page are all the slave sees.

Top module: `regpage_slave`

## Requirements
- R1: `ready_o` is high only in a cycle where both `sel_i` and `en_i` are high. It is never high in the setup cycle (`sel_i`=1, `en_i`=0) or while idle.
- R2: Every access phase has exactly `WAIT_STATES` cycles with `ready_o` low, followed by one completion cycle with `ready_o` high. The default is 2. With 0, a transfer takes exactly two cycles, setup then access.
- R3: A completed, error-free write stores `wdata_i` into register `addr_i[5:2]`, and a later read returns the stored value. Writable registers read as zero after reset.
- R4: Address bits [1:0] are ignored when a register is selected.
- R5: An access with any of `addr_i[9:6]` nonzero is a miss inside the page. It completes with `err_o`=1, read data zero, and no register changed.
- R6: A register whose bit is set in `RO_MASK` is read-only. By default these are registers 12 to 15. A read-only register reads as 0xA5A5_0000 plus its index, and a read of it completes with `err_o`=0. A write to it completes with `err_o`=1 and leaves the value unchanged.
- R7: `err_o` is high only in a completion cycle. Every completed access that is neither a miss nor a read-only write has `err_o`=0.
- R8: `rdata_o` is zero in every cycle except the completion cycle of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Page selected for a transfer |
| en_i | input | 1 | Access phase indicator |
| wr_i | input | 1 | 1 for a write, 0 for a read |
| addr_i | input | ADDR_W (10) | Byte offset within the page |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Read data, zero outside a read completion |
| ready_o | output | 1 | Transfer completes this cycle |
| err_o | output | 1 | Completing transfer is aborted |

## Verification
Wait-state insertion and error detection act in the same transfer. The wait counter sets when the completion cycle occurs, and the error flag must appear in exactly that cycle and in no wait cycle before it. Writes to read-only registers and accesses that miss the bank are run through the full wait sequence. The bench counts the low-ready cycles and checks that the error flag and the zero read data show up only in the completion cycle. A read-back afterwards confirms that the aborted write left the register untouched.

// File: rtl/regpage_pkg.sv
package regpage_pkg;

   // Identification constant returned by a read-only register
   function automatic logic [31:0] ro_value(input int unsigned index);
      return 32'hA5A5_0000 + 32'(index);
   endfunction

endpackage

// File: rtl/regpage_decode.sv
module regpage_decode #(
   parameter int unsigned ADDR_W   = 10,
   parameter int unsigned NUM_REGS = 16,
   parameter logic [NUM_REGS-1:0] RO_MASK = '0,
   localparam int unsigned IDX_W   = $clog2(NUM_REGS),
   localparam int unsigned HI_LSB  = 2 + IDX_W
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic [IDX_W-1:0]  idx_o,
   output logic              hit_o,
   output logic              ro_o
);

   if (ADDR_W <= HI_LSB) begin : g_bad_window
      $error("page must be larger than the register bank");
   end

   logic unused_lane_bits;
   assign unused_lane_bits = ^addr_i[1:0];

   assign idx_o = addr_i[HI_LSB-1:2];
   assign hit_o = (addr_i[ADDR_W-1:HI_LSB] == '0);
   assign ro_o  = RO_MASK[idx_o];

endmodule

// File: rtl/regpage_waitgen.sv
module regpage_waitgen #(
   parameter int unsigned WAIT_STATES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic access_i,
   output logic ready_o
);

   if (WAIT_STATES == 0) begin : g_no_wait
      assign ready_o = access_i;
   end else begin : g_counted
      localparam int unsigned CNT_W = $clog2(WAIT_STATES + 1);
      localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_STATES);
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                   cnt_q <= '0;
         else if (!access_i || ready_o) cnt_q <= '0;
         else                          cnt_q <= cnt_q + 1'b1;
      end

      assign ready_o = access_i && (cnt_q == LAST);

      // R2
      first_access_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (access_i && !$past(access_i)) |-> !ready_o);
   end

endmodule

// File: rtl/regpage_file.sv
module regpage_file #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_REGS = 16,
   parameter logic [NUM_REGS-1:0] RO_MASK = '0,
   localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wen_i,
   input  logic [IDX_W-1:0]  widx_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [IDX_W-1:0]  ridx_i,
   output logic [DATA_W-1:0] rdata_o
);

   logic [DATA_W-1:0] regs [NUM_REGS];

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      if (RO_MASK[i]) begin : g_const
         assign regs[i] = DATA_W'(regpage_pkg::ro_value(i));
      end else begin : g_store
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                wrap_clear();
            else if (wen_i && widx_i == IDX_W'(i))     regs[i] <= wdata_i;
         end

         task automatic wrap_clear();
            regs[i] <= '0;
         endtask

         // R3
         write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wen_i && widx_i == IDX_W'(i)) |=> (regs[i] == $past(wdata_i)));
      end
   end

   assign rdata_o = regs[ridx_i];

endmodule

// File: rtl/regpage_slave.sv
module regpage_slave #(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 10,
   parameter int unsigned NUM_REGS    = 16,
   parameter int unsigned WAIT_STATES = 2,
   parameter logic [NUM_REGS-1:0] RO_MASK = 16'hF000,
   localparam int unsigned IDX_W      = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_i,
   input  logic              en_i,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              ready_o,
   output logic              err_o
);

   if (NUM_REGS < 2 || (1 << IDX_W) != NUM_REGS) begin : g_bad_regs
      $error("NUM_REGS must be a power of two, at least 2");
   end
   if (DATA_W < 16) begin : g_bad_width
      $error("DATA_W must be at least 16");
   end

   logic             access;
   logic [IDX_W-1:0] idx;
   logic             hit, ro, fault, wen;
   logic [DATA_W-1:0] bank_rdata;

   assign access = sel_i && en_i;

   regpage_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .RO_MASK(RO_MASK)) u_decode (
      .addr_i (addr_i),
      .idx_o  (idx),
      .hit_o  (hit),
      .ro_o   (ro)
   );

   regpage_waitgen #(.WAIT_STATES(WAIT_STATES)) u_waitgen (
      .clk      (clk),
      .rst_n    (rst_n),
      .access_i (access),
      .ready_o  (ready_o)
   );

   assign fault = !hit || (wr_i && ro);
   assign wen   = ready_o && wr_i && !fault;

   regpage_file #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .RO_MASK(RO_MASK)) u_file (
      .clk     (clk),
      .rst_n   (rst_n),
      .wen_i   (wen),
      .widx_i  (idx),
      .wdata_i (wdata_i),
      .ridx_i  (idx),
      .rdata_o (bank_rdata)
   );

   assign err_o   = ready_o && fault;
   assign rdata_o = (ready_o && !wr_i && hit) ? bank_rdata : '0;

   // R1
   ready_in_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |-> (sel_i && en_i));

   // R7
   err_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> ready_o);

   // R8
   rdata_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata_o != '0) |-> (ready_o && !wr_i));

   // R5
   miss_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_o && !hit) |-> (err_o && !wen));

endmodule

// File: tb/regpage_slave_bench.sv
`timescale 1ns/1ps
module regpage_slave_bench;

   localparam int unsigned WAITS = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel = 1'b0, en = 1'b0, wr = 1'b0;
   logic [9:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        ready, err;

   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   regpage_slave u_regpage_slave (
      .clk(clk), .rst_n(rst_n), .sel_i(sel), .en_i(en), .wr_i(wr),
      .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .ready_o(ready), .err_o(err)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // One full transfer; checks phase timing (R1, R2) and quiet outputs (R7, R8)
   task automatic xfer(input logic w, input logic [9:0] a, input logic [31:0] d,
                       output logic [31:0] rd, output logic e);
      int waits = 0;
      bit early = 0;
      @(negedge clk);
      sel = 1; en = 0; wr = w; addr = a; wdata = d;
      #1;
      chk(!ready && !err && rdata == 0, "R1", "setup cycle quiet", {ready, err}, 0);
      @(negedge clk);
      en = 1;
      #1;
      while (!ready && waits < 40) begin
         if (err || rdata != 0) early = 1;
         waits++;
         @(negedge clk);
         #1;
      end
      chk(waits == WAITS, "R2", "wait cycles", waits, WAITS);
      chk(!early, "R7", "no err/rdata during waits", early, 0);
      rd = rdata;
      e  = err;
      if (w) chk(rdata == 0, "R8", "rdata zero on write completion", rdata, 0);
      @(negedge clk);
      sel = 0; en = 0;
      #1;
      chk(!ready && !err && rdata == 0, "R8", "idle outputs quiet", rdata, 0);
   endtask

   task automatic t_reset();
      logic [31:0] rd; logic e;
      chk(!ready && !err && rdata == 0, "R1", "reset idle", {ready, err}, 0);
      xfer(0, 10'h000, 0, rd, e);
      chk(rd == 0 && !e, "R3", "reg0 reset zero", rd, 0);
      xfer(0, 10'h02C, 0, rd, e);
      chk(rd == 0 && !e, "R3", "reg11 reset zero", rd, 0);
   endtask

   task automatic t_readwrite();
      logic [31:0] rd; logic e;
      xfer(1, 10'h000, 32'hDEAD_BEEF, rd, e);
      chk(!e, "R7", "valid write no err", e, 0);
      xfer(1, 10'h014, 32'h1234_5678, rd, e);
      xfer(1, 10'h02C, 32'hFFFF_0001, rd, e);
      xfer(0, 10'h000, 0, rd, e);
      chk(rd == 32'hDEAD_BEEF && !e, "R3", "reg0 readback", rd, 32'hDEAD_BEEF);
      xfer(0, 10'h014, 0, rd, e);
      chk(rd == 32'h1234_5678, "R3", "reg5 readback", rd, 32'h1234_5678);
      xfer(0, 10'h02C, 0, rd, e);
      chk(rd == 32'hFFFF_0001, "R3", "reg11 readback", rd, 32'hFFFF_0001);
   endtask

   task automatic t_lowbits();
      logic [31:0] rd; logic e;
      xfer(1, 10'h00B, 32'h0BAD_F00D, rd, e);
      xfer(0, 10'h008, 0, rd, e);
      chk(rd == 32'h0BAD_F00D && !e, "R4", "reg2 via unaligned write", rd, 32'h0BAD_F00D);
      xfer(0, 10'h00A, 0, rd, e);
      chk(rd == 32'h0BAD_F00D, "R4", "reg2 via unaligned read", rd, 32'h0BAD_F00D);
   endtask

   task automatic t_readonly();
      logic [31:0] rd; logic e;
      xfer(0, 10'h030, 0, rd, e);
      chk(rd == 32'hA5A5_000C && !e, "R6", "reg12 constant", rd, 32'hA5A5_000C);
      xfer(1, 10'h03C, 32'h0000_0000, rd, e);
      chk(e == 1, "R6", "ro write err", e, 1);
      xfer(0, 10'h03C, 0, rd, e);
      chk(rd == 32'hA5A5_000F && !e, "R6", "reg15 unchanged", rd, 32'hA5A5_000F);
   endtask

   task automatic t_miss();
      logic [31:0] rd; logic e;
      xfer(0, 10'h040, 0, rd, e);
      chk(e == 1 && rd == 0, "R5", "miss read err, zero data", rd, 0);
      xfer(1, 10'h040, 32'h5555_AAAA, rd, e);
      chk(e == 1, "R5", "miss write err", e, 1);
      xfer(0, 10'h000, 0, rd, e);
      chk(rd == 32'hDEAD_BEEF, "R5", "reg0 not aliased by miss", rd, 32'hDEAD_BEEF);
      xfer(1, 10'h3FC, 32'h7777_7777, rd, e);
      chk(e == 1, "R5", "top of page miss", e, 1);
      xfer(0, 10'h03C, 0, rd, e);
      chk(rd == 32'hA5A5_000F, "R5", "reg15 not aliased by top miss", rd, 32'hA5A5_000F);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset();
      t_readwrite();
      t_lowbits();
      t_readonly();
      t_miss();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule